// File: doc/BRIEF.md
# Bidirectional GPIO Port with Analog Channel Takeover

This block is an eight-pin general-purpose I/O port. Software programs a per-pin direction mask and a per-pin output value over a small register bus. The block drives output-enable and output-value signals to the pad buffers, and it returns a mixed view of the port on reads. For a pin set as an output, a read gives the value held for driving. For a pin set as an input, a read gives the level on the pad after it has crossed a two-flop synchronizer.

The four lowest pins also serve as inputs to an analog converter. The converter supplies a channel-select code. While that code names one of pins 0 to 3, that pin is removed from digital control. Its output driver is switched off and its digital input receiver is disabled, so no current flows through a half-level digital input. A read of that bit returns 0. Any other code leaves all eight pins under normal port control. At most one pin is taken at a time.

The output-value register is not reset. Software loads it before setting direction bits. A pin whose direction bit goes from 0 to 1 drives the value already loaded on its very first enabled cycle, so the pad sees no transient.

Top module: `gpio_port_ana`

## Requirements
- R1: After reset deasserts, every direction bit is 0: `pad_oe` is 0x00 and a read at address 0x04 returns 0x00.
- R2: A write at address 0x04 loads the direction mask. A bit at 1 makes its pin an output, and `pad_oe` follows from the first cycle after the write edge. A read at 0x04 returns the mask.
- R3: A write at address 0x00 loads the output-value register, which drives `pad_out`. `pad_out` changes only after such a write.
- R4: When a direction bit goes from 0 to 1, `pad_out` for that pin already holds the previously written value in the first cycle that `pad_oe` is high.
- R5: A read at address 0x00 returns, per bit, the output-value bit where the direction bit is 1 and the synchronized pad level where it is 0.
- R6: A change on `pad_in` appears in a read at 0x00 after exactly two rising clock edges, and not after one.
- R7: A channel-select code of 0, 1, 2 or 3 takes the pin with that index. That pin's `pad_oe` bit and `pad_ie` bit are both 0. All other pins keep `pad_ie` = 1 and `pad_oe` equal to their direction bit.
- R8: A read at 0x00 returns 0 in the bit of a pin taken by the channel select.
- R9: Channel-select codes 4 to 31 take no pin: `pad_ie` is 0xFF and `pad_oe` equals the direction mask.
- R10: Writes to any address other than 0x00 and 0x04 change neither register. Reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Register address (0x00 output value, 0x04 direction) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ana_sel | input | 5 | Converter channel-select code |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_oe | output | 8 | Per-pin output-driver enable |
| pad_out | output | 8 | Per-pin output value |
| pad_ie | output | 8 | Per-pin digital input-receiver enable |

## Verification
Register writes take effect at the clock edge that samples the strobe. Both `pad_oe` and `pad_out` are valid from the half-cycle after that edge. Channel-select changes reach `pad_oe`, `pad_ie` and the read data with no clock at all, while a new pad level needs two rising edges before it is visible in a read. The bench drives every input on the falling edge and samples on the following falling edge, after the number of rising edges due for each result. The synchronizer test checks both one edge (old value) and two edges (new value) so that the latency is pinned exactly.

// File: rtl/gpio_pkg.sv
// Package: shared address map and bus width for the GPIO port.
// Assumes a byte-wide register bus with a 3-bit address.
package gpio_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] ADDR_VALUE = 3'h0;
    localparam logic [ADDR_W-1:0] ADDR_DIR   = 3'h4;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pad levels.
// Assumes each bit is independent; bus coherency is not required.
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Capture the raw pad level in the first stage.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Shift the level one stage further.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: output-value and direction registers of the port.
// Assumes decoded write enables. The value register has no reset by
// design; software must load it before enabling any driver.
module gpio_regs #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_value,
    input  logic             wr_dir,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] value_q,
    output logic [WIDTH-1:0] dir_q
);
    // Load the output value; no reset keeps the pad path free of reset muxing.
    always_ff @(posedge clk) begin
        if (wr_value) value_q <= wdata;
    end

    // Load the direction mask; reset makes every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_ana_decode.sv
// Module: decodes the converter channel-select code into a one-hot
// mask of pins taken for analog use. Only the lowest ANA_PINS pins
// may be taken; any other code produces an empty mask.
module gpio_ana_decode #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned ANA_PINS = 4,
    parameter int unsigned SEL_W    = 5
) (
    input  logic [SEL_W-1:0] ana_sel,
    output logic [WIDTH-1:0] ana_mask
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (i < ANA_PINS) begin : g_shared
            assign ana_mask[i] = (ana_sel == SEL_W'(i));
        end else begin : g_digital
            assign ana_mask[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_port_ana.sv
// Module: eight-pin GPIO port whose low pins double as analog inputs.
// Assumes a single-cycle write strobe and a combinational read.
// A selected analog pin loses its driver and input receiver and
// reads as 0; other pins behave as normal digital I/O.
module gpio_port_ana
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned ANA_PINS    = 4,
    parameter int unsigned SEL_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [SEL_W-1:0]  ana_sel,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_ie
);
    logic [WIDTH-1:0] value_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] ana_mask;
    logic [WIDTH-1:0] port_view;
    logic             wr_value;
    logic             wr_dir;

    // Decode the write strobe per register.
    assign wr_value = bus_wr && (bus_addr == ADDR_VALUE);
    assign wr_dir   = bus_wr && (bus_addr == ADDR_DIR);

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_value (wr_value),
        .wr_dir   (wr_dir),
        .wdata    (bus_wdata),
        .value_q  (value_q),
        .dir_q    (dir_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_ana_decode #(.WIDTH(WIDTH), .ANA_PINS(ANA_PINS), .SEL_W(SEL_W)) u_ana (
        .ana_sel  (ana_sel),
        .ana_mask (ana_mask)
    );

    // Pad controls: analog takeover removes driver and receiver.
    assign pad_oe  = dir_q & ~ana_mask;
    assign pad_out = value_q;
    assign pad_ie  = ~ana_mask;

    // Per-pin port view: held value for outputs, synced level for inputs.
    assign port_view = ~ana_mask & ((dir_q & value_q) | (~dir_q & pin_sync));

    // Combinational read multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_VALUE: bus_rdata = port_view;
            ADDR_DIR:   bus_rdata = dir_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ana_chk.sv
// Module: property checker for gpio_port_ana, bound to every instance.
// Observes only top-level ports.
module gpio_port_ana_chk
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned ANA_PINS = 4,
    parameter int unsigned SEL_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [SEL_W-1:0]  ana_sel,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_ie
);
    // At most one pin is ever taken for analog use.
    assert_single_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pad_ie) <= 1);

    // Codes outside the shared range take no pin.
    assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_sel >= SEL_W'(ANA_PINS)) |-> (pad_ie == {WIDTH{1'b1}}));

    // The output value moves only after a write to the value register.
    assert_value_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_VALUE) |=> $stable(pad_out));

    for (genvar i = 0; i < ANA_PINS; i++) begin : g_ana
        // A taken pin never drives.
        assert_taken_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ana_sel == SEL_W'(i)) |-> (!pad_oe[i] && !pad_ie[i]));
        // A taken pin reads back as zero.
        assert_taken_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ana_sel == SEL_W'(i) && bus_addr == ADDR_VALUE) |-> !bus_rdata[i]);
    end
endmodule

bind gpio_port_ana gpio_port_ana_chk #(
    .WIDTH(WIDTH), .ANA_PINS(ANA_PINS), .SEL_W(SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ana_sel   (ana_sel),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_ie    (pad_ie)
);

// File: tb/gpio_port_ana_tb.sv
module gpio_port_ana_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] ana_sel = 5'd31;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_ie;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ana u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_ie(pad_ie)
    );

    // Vector fields: dir, value, pad, sel, expected oe, expected read
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'h5A, 8'h3C, 8'd31, 8'h00, 8'h3C},
        {8'hFF, 8'h5A, 8'h3C, 8'd31, 8'hFF, 8'h5A},
        {8'hF0, 8'hA5, 8'h0F, 8'd4,  8'hF0, 8'hAF},
        {8'hFF, 8'hFF, 8'h00, 8'd0,  8'hFE, 8'hFE},
        {8'h0F, 8'h0F, 8'hF0, 8'd3,  8'h07, 8'hF7},
        {8'h00, 8'h00, 8'hFF, 8'd2,  8'h00, 8'hFB},
        {8'h55, 8'h33, 8'hCC, 8'd1,  8'h55, 8'h99},
        {8'hAA, 8'h0F, 8'h0F, 8'd16, 8'hAA, 8'h0F}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [7:0] exp_ie(input logic [4:0] s);
        return (s < 5'd4) ? ~(8'h01 << s) : 8'hFF;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 oe", pad_oe, 8'h00);
        bus_addr = 3'h4; #1;
        check("R1 dir read", bus_rdata, 8'h00);

        // R5 R7 R8 R9: table walk
        foreach (VEC[k]) begin
            ana_sel = 5'd31;
            bus_write(3'h0, VEC[k][39:32]);
            bus_write(3'h4, VEC[k][47:40]);
            pad_in = VEC[k][31:24];
            ana_sel = VEC[k][20:16];
            @(negedge clk); @(negedge clk);
            bus_addr = 3'h0; #1;
            check($sformatf("R5/R8 read v%0d", k), bus_rdata, VEC[k][7:0]);
            check($sformatf("R7/R9 oe v%0d", k), pad_oe, VEC[k][15:8]);
            check($sformatf("R7/R9 ie v%0d", k), pad_ie, exp_ie(VEC[k][20:16]));
            check($sformatf("R3 out v%0d", k), pad_out, VEC[k][39:32]);
        end

        // R2: direction readback and immediate effect
        ana_sel = 5'd31;
        bus_write(3'h4, 8'hA3);
        check("R2 oe", pad_oe, 8'hA3);
        bus_addr = 3'h4; #1;
        check("R2 dir read", bus_rdata, 8'hA3);

        // R4: glitch-free enable
        bus_write(3'h4, 8'h00);
        bus_write(3'h0, 8'h81);
        check("R4 out before enable", pad_out, 8'h81);
        bus_wr = 1'b1; bus_addr = 3'h4; bus_wdata = 8'h81;
        @(posedge clk); #1;
        check("R4 oe first cycle", pad_oe, 8'h81);
        check("R4 out first cycle", pad_out, 8'h81);
        @(negedge clk); bus_wr = 1'b0;

        // R6: two-edge synchronizer latency
        bus_write(3'h4, 8'h00);
        pad_in = 8'h00;
        @(negedge clk); @(negedge clk);
        pad_in = 8'h96; bus_addr = 3'h0;
        @(negedge clk);
        check("R6 after one edge", bus_rdata, 8'h00);
        @(negedge clk);
        check("R6 after two edges", bus_rdata, 8'h96);

        // R10: unmapped address
        bus_write(3'h4, 8'h3C);
        bus_write(3'h0, 8'h55);
        bus_write(3'h2, 8'hFF);
        bus_write(3'h7, 8'h00);
        bus_addr = 3'h2; #1;
        check("R10 unmapped read", bus_rdata, 8'h00);
        bus_addr = 3'h4; #1;
        check("R10 dir kept", bus_rdata, 8'h3C);
        check("R10 value kept", pad_out, 8'h55);

        // R1: reset again clears direction
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after re-reset", pad_oe, 8'h00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule